// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A synchronous static RAM with registered inputs and registered outputs. Each clock edge captures an address and a command: deselect, read or write. A read passes through the input register and then the output register, so its data appears after the second edge. A write uses late-write timing. Its address is taken on one edge and its data on the following edge. The data is then committed to the array one edge after that.

The 36-bit word is split into four 9-bit lanes, and each lane has its own active-low write enable. The bidirectional bus is modelled as an input bus `wdata_i`, an output bus `rdata_o` and a drive flag `drive_o`. The output enable and the sleep input act on `drive_o` without waiting for a clock. The system must leave one idle cycle between a read and a following write, so read data and late-write data never need the bus in the same cycle. The array depth is a parameter (default 256 words). A location that has never been written reads as unknown.

Top module: `lw_sram`

## Requirements
- R1: The word is 36 bits wide. Lane k occupies bits [9k+8:9k], and `lane_we_ni[k]` is its active-low write enable.
- R2: With `cs_ni` high at an edge, the cycle is a deselect. The array is unchanged and that command never produces a read data cycle.
- R3: With `cs_ni` low and `we_ni` high at an edge, the cycle is a read of all four lanes of `addr_i`.
- R4: With `cs_ni` and `we_ni` both low at an edge, the cycle is a write. Only lanes whose `lane_we_ni` bit is 0 are updated; the other lanes keep their contents.
- R5: Write data is taken from `wdata_i` on the edge one cycle after the edge that captured the write address. The value on `wdata_i` during the address cycle has no effect.
- R6: A read captured at edge E drives its data after edge E+1, for exactly one cycle. Reads issued on consecutive edges produce data in consecutive cycles.
- R7: A read of an address in the cycle right after a write to that address returns the new data in the written lanes and the old data in the others. The pending write is forwarded to the read.
- R8: `drive_o` is high only in a read data cycle while `oe_ni` is low, and it follows `oe_ni` without a clock edge. `rdata_o` is all zeros whenever `drive_o` is low. After reset `drive_o` is low.
- R9: While `sleep_i` is high, commands are ignored and `drive_o` is forced low at once. A write whose address was accepted before sleep still takes its data.
- R10: When a read is followed by one idle cycle and then a write, `drive_o` is low in the cycle in which the late-write data is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the control pipeline |
| cs_ni | input | 1 | Active-low chip select |
| we_ni | input | 1 | Active-low write command |
| lane_we_ni | input | 4 | Active-low per-lane write enables |
| addr_i | input | 8 | Word address |
| wdata_i | input | 36 | Write data, sampled one cycle after the write address |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Asynchronous active-high sleep |
| rdata_o | output | 36 | Read data, zero when not driving |
| drive_o | output | 1 | High when the device would drive the data bus |

## Verification
Two events can fall on the same edge. A read's output register can load while a pending late write to the same address still sits in the write pipeline register. The array is written by that same edge, so the read must take the pending lanes through forwarding. The bench provokes this by issuing the read in the cycle that carries the write data, using a partial lane mask over known old contents. It checks that every lane matches a per-lane merge of the old and new values. The bench also pairs a read data cycle with the start of a write after one idle cycle, and checks that `drive_o` drops in the write data cycle.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
`timescale 1ns/1ps
// Input register plus late-write data register.
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        lane_we_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    sleep_i,
  output op_e                     op_o,
  output logic [AW-1:0]           addr_o,
  output logic                    pend_v_o,
  output logic [AW-1:0]           pend_addr_o,
  output logic [LANES-1:0]        pend_lanes_o,
  output logic [LANES*LANE_W-1:0] pend_data_o
);
  op_e                     op_q, op_d;
  logic [AW-1:0]           addr_q;
  logic [LANES-1:0]        lanes_q;
  logic                    pend_v_q;
  logic [AW-1:0]           pend_addr_q;
  logic [LANES-1:0]        pend_lanes_q;
  logic [LANES*LANE_W-1:0] pend_data_q;

  always_comb begin
    if (sleep_i || cs_ni) op_d = OP_IDLE;
    else if (we_ni)       op_d = OP_READ;
    else                  op_d = OP_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_IDLE;
      pend_v_q <= 1'b0;
    end else begin
      op_q     <= op_d;
      pend_v_q <= (op_q == OP_WRITE);
    end
  end

  always_ff @(posedge clk_i) begin
    if (op_d != OP_IDLE) begin
      addr_q  <= addr_i;
      lanes_q <= ~lane_we_ni;
    end
    // late write: data rides one edge behind its address
    if (op_q == OP_WRITE) begin
      pend_addr_q  <= addr_q;
      pend_lanes_q <= lanes_q;
      pend_data_q  <= wdata_i;
    end
  end

  assign op_o         = op_q;
  assign addr_o       = addr_q;
  assign pend_v_o     = pend_v_q;
  assign pend_addr_o  = pend_addr_q;
  assign pend_lanes_o = pend_lanes_q;
  assign pend_data_o  = pend_data_q;
endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  parameter int AW     = 8
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [LANES-1:0]        wlanes_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wlanes_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/lw_sram_rdout.sv
`timescale 1ns/1ps
// Output register with per-lane forwarding from the pending write.
module lw_sram_rdout #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_go_i,
  input  logic [AW-1:0]           rd_addr_i,
  input  logic [LANES*LANE_W-1:0] arr_rdata_i,
  input  logic                    pend_v_i,
  input  logic [AW-1:0]           pend_addr_i,
  input  logic [LANES-1:0]        pend_lanes_i,
  input  logic [LANES*LANE_W-1:0] pend_data_i,
  output logic                    rd_valid_o,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  logic                    hit;
  logic [LANES*LANE_W-1:0] merged;
  logic                    rd_valid_q;
  logic [LANES*LANE_W-1:0] rdata_q;

  assign hit = pend_v_i && (pend_addr_i == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (hit && pend_lanes_i[g]) ?
        pend_data_i[g*LANE_W +: LANE_W] : arr_rdata_i[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rd_valid_q <= rd_go_i;
      if (rd_go_i) rdata_q <= merged;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output logic [W-1:0]     rdata_o,
  output logic             drive_o
);
  op_e              op;
  logic [AW-1:0]    cmd_addr;
  logic             commit_v;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_lanes;
  logic [W-1:0]     pend_data;
  logic [W-1:0]     arr_rdata;
  logic             rd_valid;
  logic [W-1:0]     out_q;

  lw_sram_cmd #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_cmd (
    .clk_i, .rst_ni, .cs_ni, .we_ni, .lane_we_ni, .addr_i, .wdata_i, .sleep_i,
    .op_o(op), .addr_o(cmd_addr), .pend_v_o(commit_v), .pend_addr_o(pend_addr),
    .pend_lanes_o(pend_lanes), .pend_data_o(pend_data)
  );

  lw_sram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk_i, .we_i(commit_v), .waddr_i(pend_addr), .wlanes_i(pend_lanes),
    .wdata_i(pend_data), .raddr_i(cmd_addr), .rdata_o(arr_rdata)
  );

  lw_sram_rdout #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_out (
    .clk_i, .rst_ni, .rd_go_i(op == OP_READ), .rd_addr_i(cmd_addr),
    .arr_rdata_i(arr_rdata), .pend_v_i(commit_v), .pend_addr_i(pend_addr),
    .pend_lanes_i(pend_lanes), .pend_data_i(pend_data),
    .rd_valid_o(rd_valid), .rdata_o(out_q)
  );

  // oe and sleep act without a clock
  assign drive_o = rd_valid && !oe_ni && !sleep_i;
  assign rdata_o = drive_o ? out_q : '0;
endmodule

// File: rtl/lw_sram_chk.sv
`timescale 1ns/1ps
module lw_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             we_ni,
  input logic             sleep_i,
  input logic [LANES-1:0] lane_we_ni,
  input logic             drive_o,
  input logic             arr_we_i,
  input logic [LANES-1:0] arr_lanes_i
);
  logic rd_cmd, wr_cmd;
  assign rd_cmd = !cs_ni && we_ni && !sleep_i;
  assign wr_cmd = !cs_ni && !we_ni && !sleep_i;

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> !drive_o);

  assert_read_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> $past(rd_cmd, 2));

  assert_late_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_i |-> $past(wr_cmd, 2));

  assert_lane_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_i |-> (arr_lanes_i == ~$past(lane_we_ni, 2)));

  assert_sleep_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i, 2) |-> !drive_o);

  assert_dead_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_cmd) && !$past(rd_cmd, 2)) |-> !drive_o);
endmodule

bind lw_sram lw_sram_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .we_ni(we_ni),
  .sleep_i(sleep_i), .lane_we_ni(lane_we_ni), .drive_o(drive_o),
  .arr_we_i(commit_v), .arr_lanes_i(pend_lanes)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [3:0]  lane_we_ni = 4'hf;
  logic [7:0]  addr_i = '0;
  logic [35:0] wdata_i = '0;
  logic [35:0] rdata_o;
  logic        drive_o;
  logic [35:0] mdl [256];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  lw_sram dut (
    .clk_i(clk), .rst_ni, .cs_ni, .we_ni, .lane_we_ni, .addr_i, .wdata_i,
    .oe_ni, .sleep_i, .rdata_o, .drive_o
  );

  function automatic [35:0] merge(input [35:0] old_w, input [35:0] new_w, input [3:0] en);
    for (int k = 0; k < 4; k++) merge[k*9 +: 9] = en[k] ? new_w[k*9 +: 9] : old_w[k*9 +: 9];
  endfunction

  task automatic chk(input string req, input [35:0] act, input [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic drv(input logic cs, input logic we, input [3:0] ln, input [7:0] a, input [35:0] d);
    cs_ni = cs; we_ni = we; lane_we_ni = ln; addr_i = a; wdata_i = d;
  endtask

  task automatic idle(input [35:0] d); drv(1'b1, 1'b1, 4'hf, 8'h00, d); endtask

  // address cycle carries junk data; the real data follows one cycle later
  task automatic do_write(input [7:0] a, input [3:0] ln, input [35:0] d);
    tick; drv(1'b0, 1'b0, ln, a, ~d);
    tick; idle(d);
    mdl[a] = merge(mdl[a], d, ~ln);
  endtask

  task automatic do_read(input [7:0] a, input string req);
    tick; drv(1'b0, 1'b1, 4'hf, a, '0);
    tick; idle('0);
    tick; chk(req, {35'd0, drive_o}, 36'd1);
    chk(req, rdata_o, mdl[a]);
  endtask

  task automatic t_reset;
    chk("R8 reset drive", {35'd0, drive_o}, 36'd0);
    chk("R8 reset data", rdata_o, 36'd0);
  endtask

  task automatic t_full_word;
    do_write(8'h10, 4'h0, 36'h1_2345_6789);
    do_write(8'h11, 4'h0, 36'hF_EDCB_A987);
    do_read(8'h10, "R3 R5 full word 0x10");
    do_read(8'h11, "R3 R5 full word 0x11");
  endtask

  task automatic t_lanes;
    do_write(8'h20, 4'h0, 36'h0_0000_0000);
    do_write(8'h20, 4'b1010, 36'hF_FFFF_FFFF);
    do_read(8'h20, "R1 R4 lanes 0,2");
    chk("R1 R4 lane2 bits", {27'd0, rdata_o[26:18]}, 36'h1FF);
    do_write(8'h20, 4'b0111, 36'hA_AAAA_AAAA);
    do_read(8'h20, "R4 lane3 only");
    do_write(8'h20, 4'hf, 36'h5_5555_5555);
    do_read(8'h20, "R4 no lanes enabled");
  endtask

  task automatic t_forward;
    logic [35:0] exp;
    do_write(8'h30, 4'h0, 36'h3_3333_3333);
    exp = merge(mdl[8'h30], 36'hC_CCCC_CCCC, 4'b0110);
    tick; drv(1'b0, 1'b0, 4'b1001, 8'h30, '0);
    tick; drv(1'b0, 1'b1, 4'hf, 8'h30, 36'hC_CCCC_CCCC);
    mdl[8'h30] = exp;
    tick; idle('0);
    tick; chk("R7 forwarded merge", rdata_o, exp);
    do_read(8'h30, "R7 committed value");
  endtask

  task automatic t_latency;
    tick; drv(1'b0, 1'b1, 4'hf, 8'h10, '0);
    tick; drv(1'b0, 1'b1, 4'hf, 8'h11, '0);
    chk("R6 no data after first edge", {35'd0, drive_o}, 36'd0);
    tick; idle('0);
    chk("R6 first read data", rdata_o, mdl[8'h10]);
    tick; chk("R6 back-to-back read data", rdata_o, mdl[8'h11]);
    tick; chk("R6 single cycle drive", {35'd0, drive_o}, 36'd0);
  endtask

  task automatic t_deselect;
    tick; drv(1'b1, 1'b0, 4'h0, 8'h10, '0);
    tick; drv(1'b1, 1'b1, 4'h0, 8'h10, 36'h0_BAD0_BAD0);
    tick; chk("R2 deselect no drive", {35'd0, drive_o}, 36'd0);
    tick; chk("R2 deselect read slot no drive", {35'd0, drive_o}, 36'd0);
    do_read(8'h10, "R2 deselect kept contents");
  endtask

  task automatic t_oe;
    tick; drv(1'b0, 1'b1, 4'hf, 8'h11, '0);
    tick; idle('0);
    tick; oe_ni = 1'b1; #1;
    chk("R8 oe high drive", {35'd0, drive_o}, 36'd0);
    chk("R8 oe high data zero", rdata_o, 36'd0);
    oe_ni = 1'b0; #1;
    chk("R8 oe async return", rdata_o, mdl[8'h11]);
  endtask

  task automatic t_sleep;
    tick; drv(1'b0, 1'b1, 4'hf, 8'h10, '0);
    tick; idle('0);
    tick; sleep_i = 1'b1; #1;
    chk("R9 sleep forces no drive", {35'd0, drive_o}, 36'd0);
    drv(1'b0, 1'b0, 4'h0, 8'h10, '0);
    tick; drv(1'b0, 1'b1, 4'hf, 8'h10, 36'h0_DEAD_0000);
    tick; idle('0);
    tick; chk("R9 read in sleep ignored", {35'd0, drive_o}, 36'd0);
    sleep_i = 1'b0;
    do_read(8'h10, "R9 write in sleep ignored");
    tick; drv(1'b0, 1'b0, 4'h0, 8'h40, '0);
    tick; sleep_i = 1'b1; idle(36'h4_4444_4444);
    mdl[8'h40] = 36'h4_4444_4444;
    tick; sleep_i = 1'b0;
    do_read(8'h40, "R9 accepted write completes");
  endtask

  task automatic t_dead_cycle;
    tick; drv(1'b0, 1'b1, 4'hf, 8'h11, '0);
    tick; idle('0);
    tick; chk("R10 read data cycle", rdata_o, mdl[8'h11]);
    drv(1'b0, 1'b0, 4'h0, 8'h50, '0);
    tick; chk("R10 no drive in write data cycle", {35'd0, drive_o}, 36'd0);
    idle(36'h5_0505_0505);
    mdl[8'h50] = 36'h5_0505_0505;
    tick; chk("R10 no drive after write", {35'd0, drive_o}, 36'd0);
    do_read(8'h50, "R10 write after dead cycle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R6 watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_full_word;
    t_lanes;
    t_forward;
    t_latency;
    t_deselect;
    t_oe;
    t_sleep;
    t_dead_cycle;
    tick;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule